// File: doc/BRIEF.md
# Dual Wiper Position Command Unit

This unit keeps the volatile position of two digital potentiometer wipers, each a 10-bit value with 1024 steps, at wiper addresses 0 and 1. A serial front end hands it complete command words: a one-cycle strobe carrying a command code, a wiper address and a data field. The unit acts on them by loading a position directly, stepping it up or down by one, or doubling or halving it. Each operation clamps at the ends of the range.

Adjustment commands arm a repeat mode that suits push-button control. Once an increment, decrement or shift word has been accepted, each later chip-select pulse that carries no word replays the same operation on the same wiper. Any other word disarms the repeat. A nonvolatile sequencer can overwrite either wiper through a dedicated load port, and that load takes precedence over serial activity in the same cycle. A registered read port returns the position of any wiper.

Top module: `wiper_cmd_unit`

## Requirements
- R1: After synchronous reset both wipers hold midscale (512), `rd_data` is 0 and the repeat mode is disarmed.
- R2: A word with command code 11 loads `word_data[9:0]` into the wiper at `word_addr` (0 or 1). The other wiper is unchanged and data bits above bit 9 are ignored.
- R3: Code 4 adds one to the addressed wiper and holds at 1023. Code 5 subtracts one and holds at 0.
- R4: Code 6 doubles the addressed wiper and clamps to 1023. Code 7 halves it by a logical right shift.
- R5: For codes 4 to 7 the data field has no effect on the result.
- R6: After a word with code 4 to 7 to address 0 or 1, every `bare_strobe` cycle without `word_vld` repeats that operation on that wiper.
- R7: A word with any other code, or with an address of 2 or more, disarms the repeat mode. A `bare_strobe` while disarmed changes nothing.
- R8: Code 0 (no operation) leaves both wipers unchanged.
- R9: A word whose address is 2 or more changes no wiper.
- R10: `nv_load` writes `nv_data` into wiper `nv_addr` in the same cycle. Any `word_vld` or `bare_strobe` in that cycle is dropped, and the repeat mode is kept as it was.
- R11: `rd_data` shows the position of wiper `rd_addr` as sampled at the previous clock edge. An address of 2 or more reads as 0.
- R12: When `word_vld` and `bare_strobe` are both high, only the word is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | A complete command word is present this cycle |
| word_cmd | input | 4 | Command code |
| word_addr | input | 4 | Wiper address |
| word_data | input | 16 | Data field; bits 9:0 are the position for code 11 |
| bare_strobe | input | 1 | Chip-select pulse that carried no new word |
| nv_load | input | 1 | Load request from the nonvolatile sequencer |
| nv_addr | input | 4 | Wiper address for the load |
| nv_data | input | 10 | Position value for the load |
| rd_addr | input | 4 | Wiper address to read |
| wiper_pos | output | 20 | Wiper 1 in bits 19:10, wiper 0 in bits 9:0 |
| rd_data | output | 10 | Registered read of the selected wiper |

## Verification
The hardest state to reach from the ports is a repeat mode that has outlived other activity. This covers a repeat that survives a sequencer load, and a repeat re-targeted by a word that arrives together with a strobe. The stimulus arms a repeat, then collides a word with a strobe, then collides a sequencer load with both. It then sends a bare strobe to show which wiper the replay now follows. Clamping is reached by first direct-loading values near the ends of the range, then driving strobes past them.

// File: rtl/wcu_pkg.sv
package wcu_pkg;
  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_NOP   = 4'd0;
  localparam logic [CMD_W-1:0] CMD_INC   = 4'd4;
  localparam logic [CMD_W-1:0] CMD_DEC   = 4'd5;
  localparam logic [CMD_W-1:0] CMD_SHL   = 4'd6;
  localparam logic [CMD_W-1:0] CMD_SHR   = 4'd7;
  localparam logic [CMD_W-1:0] CMD_WRITE = 4'd11;

  // Low two bits of codes 4..7 select the adjustment.
  typedef enum logic [1:0] {
    ADJ_INC = 2'd0,
    ADJ_DEC = 2'd1,
    ADJ_SHL = 2'd2,
    ADJ_SHR = 2'd3
  } adj_op_t;
endpackage

// File: rtl/wcu_decode.sv
module wcu_decode
  import wcu_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int NUM_WIPERS = 2
) (
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_write,
  output logic              is_adj,
  output adj_op_t           adj_op,
  output logic              addr_ok
);
  localparam logic [ADDR_W-1:0] NUM_A = ADDR_W'(NUM_WIPERS);

  always_comb begin
    is_write = (cmd == CMD_WRITE);
    is_adj   = (cmd == CMD_INC) || (cmd == CMD_DEC) ||
               (cmd == CMD_SHL) || (cmd == CMD_SHR);
    adj_op   = adj_op_t'(cmd[1:0]);
    addr_ok  = (addr < NUM_A);
  end
endmodule

// File: rtl/wcu_step.sv
module wcu_step
  import wcu_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic [POS_W-1:0] cur,
  input  adj_op_t          op,
  output logic [POS_W-1:0] nxt
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  always_comb begin
    unique case (op)
      ADJ_INC: nxt = (cur == POS_MAX) ? POS_MAX : cur + 1'b1;
      ADJ_DEC: nxt = (cur == POS_MIN) ? POS_MIN : cur - 1'b1;
      ADJ_SHL: nxt = cur[POS_W-1] ? POS_MAX : {cur[POS_W-2:0], 1'b0};
      ADJ_SHR: nxt = {1'b0, cur[POS_W-1:1]};
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/wcu_repeat.sv
module wcu_repeat
  import wcu_pkg::*;
#(
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             cancel,
  input  adj_op_t          op_in,
  input  logic [IDX_W-1:0] idx_in,
  output logic             armed,
  output adj_op_t          op_q,
  output logic [IDX_W-1:0] idx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      op_q  <= ADJ_INC;
      idx_q <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      op_q  <= op_in;
      idx_q <= idx_in;
    end else if (cancel) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/wiper_cmd_unit.sv
module wiper_cmd_unit
  import wcu_pkg::*;
#(
  parameter int POS_W      = 10,
  parameter int NUM_WIPERS = 2,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        word_vld,
  input  logic [CMD_W-1:0]            word_cmd,
  input  logic [ADDR_W-1:0]           word_addr,
  input  logic [DATA_W-1:0]           word_data,
  input  logic                        bare_strobe,
  input  logic                        nv_load,
  input  logic [ADDR_W-1:0]           nv_addr,
  input  logic [POS_W-1:0]            nv_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [NUM_WIPERS*POS_W-1:0] wiper_pos,
  output logic [POS_W-1:0]            rd_data
);
  localparam int IDX_W = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;
  localparam logic [ADDR_W-1:0] NUM_A   = ADDR_W'(NUM_WIPERS);
  localparam logic [POS_W-1:0]  POS_MID = POS_W'(1) << (POS_W - 1);

  logic [POS_W-1:0] wpos [NUM_WIPERS];

  // Word decode
  logic    w_is_write, w_is_adj, w_addr_ok;
  adj_op_t w_op;

  wcu_decode #(.ADDR_W(ADDR_W), .NUM_WIPERS(NUM_WIPERS)) dec_i (
    .cmd      (word_cmd),
    .addr     (word_addr),
    .is_write (w_is_write),
    .is_adj   (w_is_adj),
    .adj_op   (w_op),
    .addr_ok  (w_addr_ok)
  );

  // Arbitration: sequencer load > word > bare strobe
  logic accept_word, accept_strobe;
  assign accept_word   = word_vld && !nv_load;
  assign accept_strobe = bare_strobe && !word_vld && !nv_load;

  logic             rep_armed;
  adj_op_t          rep_op;
  logic [IDX_W-1:0] rep_idx;
  logic             arm, cancel;

  assign arm    = accept_word && w_is_adj && w_addr_ok;
  assign cancel = accept_word && !(w_is_adj && w_addr_ok);

  wcu_repeat #(.IDX_W(IDX_W)) rep_i (
    .clk    (clk),
    .rst    (rst),
    .arm    (arm),
    .cancel (cancel),
    .op_in  (w_op),
    .idx_in (word_addr[IDX_W-1:0]),
    .armed  (rep_armed),
    .op_q   (rep_op),
    .idx_q  (rep_idx)
  );

  // One shared adjustment path
  logic [IDX_W-1:0] tgt_idx;
  adj_op_t          tgt_op;
  logic             do_adj, do_write, nv_ok;
  logic [POS_W-1:0] step_nxt;

  assign tgt_idx  = accept_word ? word_addr[IDX_W-1:0] : rep_idx;
  assign tgt_op   = accept_word ? w_op : rep_op;
  assign do_adj   = arm || (accept_strobe && rep_armed);
  assign do_write = accept_word && w_is_write && w_addr_ok;
  assign nv_ok    = nv_load && (nv_addr < NUM_A);

  wcu_step #(.POS_W(POS_W)) step_i (
    .cur (wpos[tgt_idx]),
    .op  (tgt_op),
    .nxt (step_nxt)
  );

  logic [DATA_W-POS_W-1:0] unused_data_hi;
  assign unused_data_hi = word_data[DATA_W-1:POS_W];

  for (genvar gi = 0; gi < NUM_WIPERS; gi++) begin : g_wiper
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
    always_ff @(posedge clk) begin
      if (rst)
        wpos[gi] <= POS_MID;
      else if (nv_ok && nv_addr[IDX_W-1:0] == MY_IDX)
        wpos[gi] <= nv_data;
      else if (do_write && word_addr[IDX_W-1:0] == MY_IDX)
        wpos[gi] <= word_data[POS_W-1:0];
      else if (do_adj && tgt_idx == MY_IDX)
        wpos[gi] <= step_nxt;
    end
    assign wiper_pos[gi*POS_W +: POS_W] = wpos[gi];
  end

  // Registered read mux
  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_addr < NUM_A)
      rd_data <= wpos[rd_addr[IDX_W-1:0]];
    else
      rd_data <= '0;
  end
endmodule

// File: rtl/wcu_chk.sv
module wcu_chk
  import wcu_pkg::*;
#(
  parameter int POS_W      = 10,
  parameter int NUM_WIPERS = 2,
  parameter int ADDR_W     = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        word_vld,
  input logic [CMD_W-1:0]            word_cmd,
  input logic [ADDR_W-1:0]           word_addr,
  input logic                        bare_strobe,
  input logic                        nv_load,
  input logic [ADDR_W-1:0]           nv_addr,
  input logic [POS_W-1:0]            nv_data,
  input logic [ADDR_W-1:0]           rd_addr,
  input logic [NUM_WIPERS*POS_W-1:0] wiper_pos,
  input logic [POS_W-1:0]            rd_data
);
  localparam logic [ADDR_W-1:0] NUM_A   = ADDR_W'(NUM_WIPERS);
  localparam logic [POS_W-1:0]  POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] w0;
  assign w0 = wiper_pos[POS_W-1:0];

  // R3
  inc_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !nv_load && word_cmd == CMD_INC && word_addr == '0 && w0 == POS_MAX)
      |=> (w0 == POS_MAX));

  // R6
  repeat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !nv_load && word_cmd == CMD_INC && word_addr == '0 && w0 < POS_MAX - 1'b1)
      ##1 (bare_strobe && !word_vld && !nv_load)
      |=> (w0 == POS_W'($past(w0) + 1'b1)));

  // R7
  disarmed_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !nv_load && word_cmd == CMD_NOP)
      ##1 (bare_strobe && !word_vld && !nv_load)
      |=> $stable(wiper_pos));

  // R8
  nop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !nv_load && word_cmd == CMD_NOP) |=> $stable(wiper_pos));

  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !nv_load && word_addr >= NUM_A) |=> $stable(wiper_pos));

  // R10
  nv_load_chk: assert property (@(posedge clk) disable iff (rst)
    (nv_load && nv_addr == '0) |=> (w0 == $past(nv_data)));

  // R11
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= NUM_A) |=> (rd_data == '0));

  // R11
  rd_w0_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == '0) |=> (rd_data == $past(w0)));
endmodule

bind wiper_cmd_unit wcu_chk #(
  .POS_W(POS_W), .NUM_WIPERS(NUM_WIPERS), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .word_vld(word_vld), .word_cmd(word_cmd),
  .word_addr(word_addr), .bare_strobe(bare_strobe), .nv_load(nv_load),
  .nv_addr(nv_addr), .nv_data(nv_data), .rd_addr(rd_addr),
  .wiper_pos(wiper_pos), .rd_data(rd_data)
);

// File: tb/wiper_cmd_unit_tb.sv
module wiper_cmd_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic [3:0]  word_cmd = '0;
  logic [3:0]  word_addr = '0;
  logic [15:0] word_data = '0;
  logic        bare_strobe = 1'b0;
  logic        nv_load = 1'b0;
  logic [3:0]  nv_addr = '0;
  logic [9:0]  nv_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [19:0] wiper_pos;
  logic [9:0]  rd_data;

  always #4 clk = ~clk;  // 125 MHz

  wiper_cmd_unit dut_i (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_cmd(word_cmd),
    .word_addr(word_addr), .word_data(word_data), .bare_strobe(bare_strobe),
    .nv_load(nv_load), .nv_addr(nv_addr), .nv_data(nv_data),
    .rd_addr(rd_addr), .wiper_pos(wiper_pos), .rd_data(rd_data)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R1";
  bit    started  = 1'b0;

  // Behavioural reference model
  int mw [2];
  int rd_m;
  bit rep_on;
  int rep_op, rep_a;

  function automatic int apply_op(int code, int v);
    case (code)
      4: return (v + 1 > 1023) ? 1023 : v + 1;
      5: return (v - 1 < 0) ? 0 : v - 1;
      6: return (v * 2 > 1023) ? 1023 : v * 2;
      default: return v / 2;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mw[0] = 512; mw[1] = 512; rd_m = 0; rep_on = 0; rep_op = 4; rep_a = 0;
    end else begin
      rd_m = (rd_addr < 2) ? mw[rd_addr] : 0;
      if (nv_load) begin
        if (nv_addr < 2) mw[nv_addr] = int'(nv_data);
      end else if (word_vld) begin
        if (word_addr < 2 && word_cmd >= 4 && word_cmd <= 7) begin
          mw[word_addr] = apply_op(int'(word_cmd), mw[word_addr]);
          rep_on = 1; rep_op = int'(word_cmd); rep_a = int'(word_addr);
        end else begin
          rep_on = 0;
          if (word_addr < 2 && word_cmd == 11) mw[word_addr] = int'(word_data) % 1024;
        end
      end else if (bare_strobe && rep_on) begin
        mw[rep_a] = apply_op(rep_op, mw[rep_a]);
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk({phase, " model w0"}, int'(wiper_pos[9:0]), mw[0]);
      chk({phase, " model w1"}, int'(wiper_pos[19:10]), mw[1]);
      chk({phase, " model rd"}, int'(rd_data), rd_m);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected at most 5000", wd);
      summary();
    end
  end

  task automatic word(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d,
                      input bit strobe = 0);
    word_vld = 1; word_cmd = c; word_addr = a; word_data = d; bare_strobe = strobe;
    @(negedge clk);
    word_vld = 0; bare_strobe = 0;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      bare_strobe = 1;
      @(negedge clk);
      bare_strobe = 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int w(int i);
    return (i == 0) ? int'(wiper_pos[9:0]) : int'(wiper_pos[19:10]);
  endfunction

  initial begin
    idle(2);
    rst = 0;
    started = 1;
    chk("R1 reset w0", w(0), 512);
    chk("R1 reset w1", w(1), 512);
    chk("R1 reset rd", int'(rd_data), 0);
    phase = "R7";
    strobe(1);
    chk("R7 strobe before arm", w(0), 512);

    phase = "R2";
    word(4'd11, 4'd0, 16'hFC05);
    chk("R2 write w0 upper bits ignored", w(0), 5);
    chk("R2 other wiper kept", w(1), 512);
    word(4'd11, 4'd1, 16'd1020);

    phase = "R5";
    word(4'd4, 4'd1, 16'h00FF);
    chk("R5 inc ignores data", w(1), 1021);
    phase = "R6";
    strobe(2);
    chk("R6 repeat inc", w(1), 1023);
    phase = "R3";
    strobe(1);
    chk("R3 inc clamps", w(1), 1023);
    word(4'd5, 4'd0, 16'h00AB);
    chk("R3 dec", w(0), 4);
    strobe(5);
    chk("R3 dec clamps", w(0), 0);

    phase = "R4";
    word(4'd11, 4'd0, 16'd300);
    word(4'd6, 4'd0, 16'd0);
    chk("R4 shl", w(0), 600);
    strobe(1);
    chk("R4 shl clamps", w(0), 1023);
    word(4'd7, 4'd0, 16'hFFFF);
    chk("R4 shr", w(0), 511);
    strobe(1);
    chk("R4 shr odd", w(0), 255);

    phase = "R8";
    word(4'd0, 4'd0, 16'h0123);
    chk("R8 nop", w(0), 255);
    strobe(1);
    chk("R7 nop cancels repeat", w(0), 255);
    chk("R8 w1 kept", w(1), 1023);

    phase = "R9";
    word(4'd4, 4'd0, 16'd0);
    word(4'd4, 4'd3, 16'd0);
    chk("R9 bad address", w(0), 256);
    strobe(1);
    chk("R7 bad address cancels", w(0), 256);
    phase = "R7";
    word(4'd4, 4'd0, 16'd0);
    word(4'd9, 4'd0, 16'd0);
    strobe(1);
    chk("R7 undefined code cancels", w(0), 257);

    phase = "R12";
    word(4'd4, 4'd0, 16'd0);
    word(4'd5, 4'd1, 16'd0, 1);
    chk("R12 word wins w0", w(0), 258);
    chk("R12 word wins w1", w(1), 1022);

    phase = "R10";
    nv_load = 1; nv_addr = 4'd1; nv_data = 10'd777;
    word(4'd11, 4'd0, 16'd5, 1);
    nv_load = 0;
    chk("R10 nv load", w(1), 777);
    chk("R10 word dropped", w(0), 258);
    strobe(1);
    chk("R10 repeat kept", w(1), 776);
    nv_load = 1; nv_addr = 4'd0; nv_data = 10'd900;
    idle(1);
    nv_load = 0;
    chk("R10 nv load w0", w(0), 900);

    phase = "R11";
    rd_addr = 4'd0; idle(1);
    chk("R11 read w0", int'(rd_data), 900);
    rd_addr = 4'd1; idle(1);
    chk("R11 read w1", int'(rd_data), 776);
    rd_addr = 4'd2; idle(1);
    chk("R11 read bad address", int'(rd_data), 0);

    phase = "R1";
    rst = 1; idle(2); rst = 0;
    chk("R1 re-reset w0", w(0), 512);
    chk("R1 re-reset w1", w(1), 512);
    strobe(1);
    chk("R1 repeat disarmed", w(1), 512);
    idle(2);
    summary();
  end
endmodule